// File: doc/BRIEF.md
# PCI Configuration Window Decoder

This block turns host accesses in two address windows into PCI configuration cycles aimed at one backplane slot. Two windows address the same slots. The self window at 0x6000_xxxx lets software scan for the board's own slot. The normal window at 0x6100_xxxx reaches every card on the bus. In both windows, address bits [15:11] pick the slot, so each slot takes a 2 KB stride. A slot number n drives the IDSEL line wired to PCI address bit n. Valid slots run from 11 to 31.

A host access is a one-cycle request with the address, a write flag and write data. If the access belongs to a window and is well formed, the block starts a bus cycle. During the cycle it drives a one-hot IDSEL vector, the dword register offset, the configuration read or write command and the write data. The cycle ends when a target acknowledges or when a fixed time limit runs out. An access that falls in a window but cannot be sent to the bus completes at once, and a read of it returns all ones. This covers misaligned accesses, offsets past the header, slots below 11, and normal-window accesses made before the self slot is known.

Software writes the board's own slot number into a self-slot register. Until that register has been written, the normal window is closed. Once it is written, every cycle carries a flag that says whether it targets the board itself.

Top module: `cfgwin_decoder`

## Requirements
- R1: An access is claimed only when address bits [31:16] equal 0x6000 (self window) or 0x6100 (normal window). Any other address gives no completion and no bus cycle.
- R2: The slot is address bits [15:11]. While a cycle is active, `cyc_idsel` has exactly bit n set. When no cycle is active, `cyc_idsel` is zero.
- R3: `cyc_off` carries address bits [7:2]. An access with any of address bits [10:6] set lies past the 64-byte header. It completes one cycle after the request with no bus cycle.
- R4: An access with address bits [1:0] not equal to zero completes one cycle after the request with no bus cycle. A read of it returns 0xFFFFFFFF.
- R5: An access to slot 0 to 10 completes one cycle after the request with no bus cycle and no IDSEL. A read returns 0xFFFFFFFF. IDSEL bits 0 to 10 are never driven.
- R6: A read drives `cyc_cmd` = 4'b1010 and a write drives 4'b1011. On a write, `cyc_wdata` carries the host write data.
- R7: Until the self-slot register has been written after reset, a normal-window access completes at once with no bus cycle and reads 0xFFFFFFFF. Self-window accesses are not affected.
- R8: `cyc_self` is high for every self-window cycle. For a normal-window cycle it is high only when the slot equals the stored self slot.
- R9: When `tgt_ack` is sampled high during a cycle, `host_done` pulses in the next cycle and `cyc_valid` falls. `host_rdata` then holds `tgt_rdata` for a read and zero for a write.
- R10: If no acknowledge is sampled in the 8 clock edges after `cyc_valid` rises, the cycle ends with `host_done`. A read then returns 0xFFFFFFFF. An acknowledge at the 8th edge is still accepted.
- R11: After reset, `cyc_valid`, `cyc_idsel` and `host_done` are zero, and the self slot counts as unwritten.
- R12: Every immediate completion returns 0xFFFFFFFF for a read and zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Completion read data |
| selfid_we | input | 1 | Write strobe for the self-slot register |
| selfid_wdata | input | 5 | Self slot number to store |
| cyc_valid | output | 1 | Configuration cycle in progress |
| cyc_idsel | output | 32 | One-hot IDSEL vector |
| cyc_off | output | 6 | Dword register offset |
| cyc_cmd | output | 4 | PCI command code |
| cyc_wdata | output | 32 | Cycle write data |
| cyc_self | output | 1 | Cycle targets the board's own slot |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_rdata | input | 32 | Target read data |

## Verification
The bench goes after the slot boundary between 10 and 11. A wrong compare there would either drive a reserved IDSEL bit or lose slot 11. It checks acknowledges at the 8th and 9th edges. An off-by-one timer would either drop a real card at the limit or wait one clock too long. It also tests normal-window accesses made before the self slot is written. A design that leaves the window open there would start cycles with no self slot defined. Misaligned and out-of-header offsets, unclaimed addresses, and random traffic with random card presence and acknowledge delays complete the set. Wrong decoding in any of these shows up as stray cycles, missing completions or wrong read data.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int SLOT_W = 5;
  localparam int SEL_W  = 1 << SLOT_W;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef struct packed {
    logic              claim;     // address is in one of the windows
    logic              ok;        // may be sent to the bus
    logic              self_win;  // self window hit
    logic [SLOT_W-1:0] slot;
  } dec_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUS = 1'b1} st_e;
endpackage

// File: rtl/cfgwin_addr_dec.sv
module cfgwin_addr_dec
  import cfgwin_pkg::*;
#(
  parameter logic [15:0] SELF_BASE = 16'h6000,
  parameter logic [15:0] NORM_BASE = 16'h6100,
  parameter int          SLOT_LO   = 11,
  parameter int          HDR_BYTES = 64,
  parameter int          OFF_W     = 6
) (
  input  logic [31:0]      addr,
  input  logic             selfid_vld,
  output dec_t             dec,
  output logic [OFF_W-1:0] off
);
  localparam int HDR_LSB = $clog2(HDR_BYTES);

  logic in_self, in_norm, aligned, in_hdr, slot_ok;
  logic [10:0] low;

  always_comb begin
    low      = addr[10:0];
    in_self  = (addr[31:16] == SELF_BASE);
    in_norm  = (addr[31:16] == NORM_BASE);
    aligned  = (addr[1:0] == 2'b00);
    in_hdr   = ((low >> HDR_LSB) == 11'd0);
    slot_ok  = (int'(addr[15:11]) >= SLOT_LO);
    dec.claim    = in_self | in_norm;
    dec.self_win = in_self;
    dec.slot     = addr[15:11];
    dec.ok       = aligned & in_hdr & slot_ok & (in_self | selfid_vld);
    off          = addr[OFF_W+1:2];
  end
endmodule

// File: rtl/cfgwin_selfid.sv
module cfgwin_selfid
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] wdata,
  output logic [SLOT_W-1:0] id,
  output logic              vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id  <= '0;
      vld <= 1'b0;
    end else if (we) begin
      id  <= wdata;
      vld <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgwin_cycle_ctrl.sv
module cfgwin_cycle_ctrl
  import cfgwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 6,
  parameter int TMO    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata_in,
  input  dec_t              dec,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [SLOT_W-1:0] selfid,
  input  logic              ack,
  input  logic [DATA_W-1:0] ack_data,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cyc_valid,
  output logic [SEL_W-1:0]  idsel,
  output logic [OFF_W-1:0]  off,
  output logic [3:0]        cmd,
  output logic [DATA_W-1:0] wdata,
  output logic              is_self
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [DATA_W-1:0] ONES = '1;

  st_e          st;
  logic [TW-1:0] tmr;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      rdata     <= '0;
      cyc_valid <= 1'b0;
      idsel     <= '0;
      off       <= '0;
      cmd       <= '0;
      wdata     <= '0;
      is_self   <= 1'b0;
      tmr       <= '0;
      is_wr     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req && dec.claim) begin
            if (dec.ok) begin
              st        <= ST_BUS;
              cyc_valid <= 1'b1;
              idsel     <= SEL_W'(1) << dec.slot;
              off       <= off_in;
              cmd       <= wr ? CMD_CFG_WR : CMD_CFG_RD;
              wdata     <= wr ? wdata_in : '0;
              is_self   <= dec.self_win | (dec.slot == selfid);
              is_wr     <= wr;
              tmr       <= '0;
            end else begin
              done  <= 1'b1;
              rdata <= wr ? '0 : ONES;
            end
          end
        end
        ST_BUS: begin
          if (ack || tmr == TW'(TMO - 1)) begin
            st        <= ST_IDLE;
            cyc_valid <= 1'b0;
            idsel     <= '0;
            is_self   <= 1'b0;
            done      <= 1'b1;
            rdata     <= is_wr ? '0 : (ack ? ack_data : ONES);
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter logic [15:0] SELF_BASE = 16'h6000,
  parameter logic [15:0] NORM_BASE = 16'h6100,
  parameter int          SLOT_LO   = 11,
  parameter int          HDR_BYTES = 64,
  parameter int          OFF_W     = 6,
  parameter int          DATA_W    = 32,
  parameter int          TMO       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [31:0]       host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              selfid_we,
  input  logic [4:0]        selfid_wdata,
  output logic              cyc_valid,
  output logic [31:0]       cyc_idsel,
  output logic [OFF_W-1:0]  cyc_off,
  output logic [3:0]        cyc_cmd,
  output logic [DATA_W-1:0] cyc_wdata,
  output logic              cyc_self,
  input  logic              tgt_ack,
  input  logic [DATA_W-1:0] tgt_rdata
);
  dec_t              dec;
  logic [OFF_W-1:0]  dec_off;
  logic [SLOT_W-1:0] self_id;
  logic              self_vld;

  cfgwin_selfid u_selfid (
    .clk(clk), .rst(rst), .we(selfid_we), .wdata(selfid_wdata),
    .id(self_id), .vld(self_vld)
  );

  cfgwin_addr_dec #(
    .SELF_BASE(SELF_BASE), .NORM_BASE(NORM_BASE), .SLOT_LO(SLOT_LO),
    .HDR_BYTES(HDR_BYTES), .OFF_W(OFF_W)
  ) u_dec (
    .addr(host_addr), .selfid_vld(self_vld), .dec(dec), .off(dec_off)
  );

  cfgwin_cycle_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W), .TMO(TMO)) u_ctrl (
    .clk(clk), .rst(rst), .req(host_req), .wr(host_we), .wdata_in(host_wdata),
    .dec(dec), .off_in(dec_off), .selfid(self_id),
    .ack(tgt_ack), .ack_data(tgt_rdata),
    .done(host_done), .rdata(host_rdata), .cyc_valid(cyc_valid),
    .idsel(cyc_idsel), .off(cyc_off), .cmd(cyc_cmd), .wdata(cyc_wdata),
    .is_self(cyc_self)
  );
endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk #(
  parameter int SLOT_LO = 11,
  parameter int TMO     = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        host_done,
  input logic        cyc_valid,
  input logic [31:0] cyc_idsel,
  input logic [3:0]  cyc_cmd,
  input logic        tgt_ack
);
  localparam logic [31:0] LOW_MASK = (32'd1 << SLOT_LO) - 32'd1;

  logic [15:0] vcnt;
  always_ff @(posedge clk) begin
    if (rst || !cyc_valid) vcnt <= '0;
    else                   vcnt <= vcnt + 16'd1;
  end

  assert_idsel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> $countones(cyc_idsel) == 1);
  assert_idsel_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |-> cyc_idsel == 32'd0);
  assert_no_low_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_idsel & LOW_MASK) == 32'd0);
  assert_cmd_code_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> (cyc_cmd == 4'b1010 || cyc_cmd == 4'b1011));
  assert_ack_ends_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_valid && tgt_ack |=> host_done && !cyc_valid);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    host_done |-> !cyc_valid);
  assert_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> vcnt < 16'(TMO));
endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(.SLOT_LO(SLOT_LO), .TMO(TMO)) u_chk (
  .clk(clk), .rst(rst), .host_done(host_done), .cyc_valid(cyc_valid),
  .cyc_idsel(cyc_idsel), .cyc_cmd(cyc_cmd), .tgt_ack(tgt_ack)
);

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic        host_done;
  logic [31:0] host_rdata;
  logic        selfid_we = 1'b0;
  logic [4:0]  selfid_wdata = '0;
  logic        cyc_valid, cyc_self;
  logic [31:0] cyc_idsel, cyc_wdata;
  logic [5:0]  cyc_off;
  logic [3:0]  cyc_cmd;
  logic        tgt_ack = 1'b0;
  logic [31:0] tgt_rdata = '0;

  int checks = 0, failures = 0;
  bit          m_vld = 0;
  logic [4:0]  m_id = '0;
  logic [31:0] present = '0;

  always #5 clk = ~clk;

  cfgwin_decoder u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind: 0 unclaimed, 1 immediate completion, 2 bus cycle
  function automatic int exp_kind(input logic [31:0] a);
    bit s = (a[31:16] == 16'h6000), n = (a[31:16] == 16'h6100);
    if (!s && !n) return 0;
    if (a[1:0] != 0 || a[10:6] != 0 || a[15:11] < 5'd11 || (n && !m_vld)) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] card_data(input logic [31:0] a);
    return 32'hC0DE_0000 | (32'(a[15:11]) << 8) | 32'(a[7:2]);
  endfunction

  task automatic set_self(input logic [4:0] id);
    @(negedge clk); selfid_we = 1'b1; selfid_wdata = id;
    @(negedge clk); selfid_we = 1'b0;
    m_vld = 1; m_id = id;
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                        input int delay, input string req);
    int kind = exp_kind(a);
    bit pres = present[a[15:11]];
    int expk, gotk;
    logic [31:0] got_rd, exp_rd;
    @(negedge clk);
    host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    if (kind == 0) begin
      check(!host_done && !cyc_valid, req, "R1 unclaimed", {host_done, cyc_valid}, 0);
      repeat (3) @(negedge clk);
      check(!host_done && !cyc_valid, req, "R1 still quiet", {host_done, cyc_valid}, 0);
      return;
    end
    if (kind == 1) begin
      check(host_done && !cyc_valid, req, "immediate done", {host_done, cyc_valid}, 2);
      check(host_rdata == (wr ? 32'd0 : 32'hFFFF_FFFF), req, "R12 imm rdata",
            host_rdata, wr ? 32'd0 : 32'hFFFF_FFFF);
      return;
    end
    check(cyc_valid && !host_done, req, "R2 cycle start", {host_done, cyc_valid}, 1);
    check(cyc_idsel == (32'd1 << a[15:11]), req, "R2 idsel", cyc_idsel, 32'd1 << a[15:11]);
    check(cyc_off == a[7:2], req, "R3 offset", 32'(cyc_off), 32'(a[7:2]));
    check(cyc_cmd == (wr ? 4'b1011 : 4'b1010), req, "R6 cmd", 32'(cyc_cmd),
          wr ? 32'hB : 32'hA);
    if (wr) check(cyc_wdata == wd, req, "R6 wdata", cyc_wdata, wd);
    check(cyc_self == (a[31:16] == 16'h6000 || a[15:11] == m_id), req, "R8 self flag",
          32'(cyc_self), 32'(a[31:16] == 16'h6000 || a[15:11] == m_id));
    expk = (pres && delay <= 8) ? delay : 8;
    exp_rd = wr ? 32'd0 : ((pres && delay <= 8) ? card_data(a) : 32'hFFFF_FFFF);
    gotk = 0; got_rd = '0;
    for (int k = 1; k <= 12; k++) begin
      tgt_ack = pres && (k == delay);
      tgt_rdata = card_data(a);
      @(negedge clk);
      tgt_ack = 1'b0;
      if (host_done) begin
        gotk = k; got_rd = host_rdata;
        check(!cyc_valid, req, "R9 valid drops", 32'(cyc_valid), 0);
        break;
      end
    end
    check(gotk == expk, req, (pres && delay <= 8) ? "R9 ack edge" : "R10 timeout edge",
          gotk, expk);
    check(got_rd == exp_rd, req, (pres && delay <= 8) ? "R9 rdata" : "R10 empty rdata",
          got_rd, exp_rd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    present = 32'hA5A5_F800;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cyc_valid && cyc_idsel == 0 && !host_done, "R11", "reset outputs",
          {host_done, cyc_valid}, 0);
    // R11/R7: normal window closed before self slot written
    access({16'h6100, 5'd29, 11'h000}, 0, 0, 1, "R7");
    access({16'h6000, 5'd29, 11'h000}, 0, 0, 2, "R7");
    set_self(5'd29);
    access({16'h6100, 5'd29, 11'h000}, 0, 0, 3, "R7");
    access({16'h6100, 5'd15, 11'h008}, 1, 32'h1234_5678, 1, "R8");
    access({16'h6200, 5'd29, 11'h000}, 0, 0, 1, "R1");
    access({16'h6000, 5'd10, 11'h000}, 0, 0, 1, "R5");
    access({16'h6000, 5'd11, 11'h03C}, 0, 0, 2, "R5");
    access({16'h6000, 5'd31, 11'h000}, 0, 0, 1, "R2");
    access({16'h6000, 5'd31, 11'h002}, 0, 0, 1, "R4");
    access({16'h6100, 5'd31, 11'h001}, 1, 32'h1, 1, "R4");
    access({16'h6000, 5'd31, 11'h040}, 0, 0, 1, "R3");
    access({16'h6000, 5'd31, 11'h400}, 1, 32'h5, 1, "R3");
    access({16'h6000, 5'd31, 11'h000}, 0, 0, 8, "R10");
    access({16'h6000, 5'd31, 11'h000}, 0, 0, 9, "R10");
    access({16'h6000, 5'd12, 11'h010}, 0, 0, 1, "R10");
    access({16'h6000, 5'd12, 11'h010}, 1, 32'hDEAD_BEEF, 3, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] hi;
      logic [10:0] lo;
      int w = $urandom % 4;
      hi = (w == 0) ? 16'h6000 : (w == 3) ? 16'h7000 + 16'($urandom % 8) : 16'h6100;
      lo = ($urandom % 5 == 0) ? 11'($urandom) : 11'(($urandom % 16) << 2);
      if (i % 97 == 50) set_self(5'($urandom));
      access({hi, 5'($urandom), lo}, 1'($urandom), $urandom, 1 + $urandom % 10, "rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule